// File: doc/BRIEF.md
# Link Pulse Burst Generator

This block drives the link integrity pulse line of a twisted-pair 10 Mb/s port. In normal mode it sends one isolated pulse per period, which tells the far end that the link is alive. In auto-negotiation mode it sends, once per period, a burst of clock pulses at a fixed spacing. Between each pair of clock pulses there is an optional data pulse, and the burst carries a 16-bit code word this way.

A single period timer paces both formats. The mode input is sampled at the start of each period, so the format never changes halfway through a period. The code word is captured when a burst begins. A burst is 17 clock pulses long, with a data pulse inserted for every one bit of the word. A one-cycle strobe marks the end of each burst. All durations are parameters counted in clock cycles. The defaults assume a 10 MHz clock: a pulse is one cycle wide, the period is 16 ms, the clock pulse spacing is 125 µs and the data pulse offset is 62.5 µs. Pulse shaping in the analog domain is outside this block.

Top module: `link_pulse_gen`

## Requirements
- R1: Every pulse on `pulse_o` is high for exactly PULSE_W consecutive cycles, followed by at least one low cycle.
- R2: With `mode_i`=0 (normal) and `en_i` high, a single pulse starts every NLP_PERIOD cycles. The first pulse is high in the cycle right after the first rising clock edge at which `en_i` is sampled high.
- R3: With `mode_i`=1 (auto-negotiation), a burst starts on the same first edge. It holds 17 clock pulses, and clock pulse k (k = 0..16) starts CLK_SPACING*k cycles after the burst start.
- R4: Code bit k of `code_i` (bit 0 first, bit 15 last) produces a data pulse that starts DATA_OFFSET cycles after clock pulse k when the bit is 1. No pulse is sent there when the bit is 0.
- R5: One burst holds 17 plus popcount(code word) pulses, so between 17 and 33 pulses.
- R6: In auto-negotiation mode, bursts start every FLP_PERIOD cycles.
- R7: The code word is captured at the first clock pulse of a burst. A change of `code_i` during a burst affects only the next burst.
- R8: `done_o` is high for exactly one cycle per burst: the cycle right after the last high cycle of clock pulse 16. It never rises in normal mode.
- R9: While `en_i` is low, `pulse_o` and `done_o` are low, any burst in progress is abandoned and the period timer is held at its start. When `en_i` goes high again, a fresh period starts at once.
- R10: `mode_i` is sampled only at the start of a period. A change mid-period takes effect at the next period start, and that period uses the length that belongs to the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables pulse generation; low holds the block idle |
| mode_i | input | 1 | 0 = normal single pulses, 1 = auto-negotiation bursts |
| code_i | input | 16 | Code word sent in each burst, bit 0 first |
| pulse_o | output | 1 | Link pulse line |
| done_o | output | 1 | One-cycle strobe after the last pulse of a burst |

## Verification
The assertions take the timing parameters to be well ordered: PULSE_W+1 is smaller than DATA_OFFSET, DATA_OFFSET+PULSE_W is smaller than CLK_SPACING, and each period is longer than a full burst. Under these conditions pulses never touch and the end strobe always falls on a low cycle of the line. The bench uses a small parameter set that meets these conditions. It changes the code word and the mode only at chosen cycles in the middle of a period, and it drops the enable in the middle of a burst. Every run starts from reset, so each period start is known exactly.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    typedef enum logic {
        LPG_NORMAL = 1'b0,
        LPG_NEGOT  = 1'b1
    } lpg_mode_e;

    localparam int LPG_CODE_BITS  = 16;
    localparam int LPG_CLK_PULSES = LPG_CODE_BITS + 1;

    typedef struct packed {
        logic clk_hit;
        logic data_hit;
    } lpg_hit_t;

    function automatic int lpg_cw(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lpg_period_timer.sv
module lpg_period_timer
    import lpg_pkg::*;
#(
    parameter int NLP_PERIOD = 160000,
    parameter int FLP_PERIOD = 160000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  lpg_mode_e mode_i,
    output logic      start_o
);
    localparam int MAXP = (NLP_PERIOD > FLP_PERIOD) ? NLP_PERIOD : FLP_PERIOD;
    localparam int PW   = lpg_cw(MAXP);

    logic [PW-1:0] pcnt_q;
    lpg_mode_e     mode_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit   = (mode_q == LPG_NEGOT) ? PW'(FLP_PERIOD - 1) : PW'(NLP_PERIOD - 1);
        start_o = en_i && (pcnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            pcnt_q <= '0;
            mode_q <= LPG_NORMAL;
        end else begin
            if (start_o) mode_q <= mode_i;
            pcnt_q <= (pcnt_q == limit) ? '0 : pcnt_q + 1'b1;
        end
    end

    // R2/R6: two period starts are never adjacent
    p_start_gap_r6: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R10: the counter never runs past the longest period
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        pcnt_q < PW'(MAXP));

endmodule

// File: rtl/lpg_burst_seq.sv
module lpg_burst_seq
    import lpg_pkg::*;
#(
    parameter int CLK_SPACING = 1250,
    parameter int DATA_OFFSET = 625,
    parameter int PULSE_W     = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic                     start_i,
    input  logic [LPG_CODE_BITS-1:0] code_i,
    output lpg_hit_t                 hit_o,
    output logic                     done_o
);
    localparam int SW  = lpg_cw(CLK_SPACING);
    localparam int SLW = lpg_cw(LPG_CLK_PULSES);

    logic                     active_q;
    logic [SLW-1:0]           slot_q;
    logic [SW-1:0]            off_q;
    logic [LPG_CODE_BITS-1:0] word_q;
    logic                     last_slot;

    always_comb begin
        last_slot      = (slot_q == SLW'(LPG_CODE_BITS));
        hit_o.clk_hit  = start_i || (active_q && (off_q == '0));
        hit_o.data_hit = active_q && !last_slot && (off_q == SW'(DATA_OFFSET))
                         && word_q[slot_q[3:0]];
        done_o         = en_i && active_q && last_slot && (off_q == SW'(PULSE_W + 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            off_q    <= '0;
            word_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            slot_q   <= '0;
            off_q    <= SW'(1);
            word_q   <= code_i;
        end else if (active_q) begin
            if (done_o) begin
                active_q <= 1'b0;
            end else if (off_q == SW'(CLK_SPACING - 1)) begin
                off_q  <= '0;
                slot_q <= slot_q + 1'b1;
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    // R3: the slot index never passes the final clock pulse
    p_slot_bound_r3: assert property (@(posedge clk) disable iff (rst)
        active_q |-> slot_q <= SLW'(LPG_CODE_BITS));

    // R4: a data slot never coincides with a clock slot
    p_data_apart_r4: assert property (@(posedge clk) disable iff (rst)
        hit_o.data_hit |-> !hit_o.clk_hit);

    // R8: the end strobe lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/lpg_pulse_stretch.sv
module lpg_pulse_stretch
    import lpg_pkg::*;
#(
    parameter int PULSE_W = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int CW = lpg_cw(PULSE_W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i)          cnt_q <= '0;
        else if (trig_i)           cnt_q <= CW'(PULSE_W);
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = en_i && (cnt_q != '0);

    // R1: no new trigger arrives while a pulse is still running
    p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > CW'(1)) |-> !trig_i);

endmodule

// File: rtl/link_pulse_gen.sv
module link_pulse_gen
    import lpg_pkg::*;
#(
    parameter int PULSE_W     = 1,
    parameter int NLP_PERIOD  = 160000,
    parameter int FLP_PERIOD  = 160000,
    parameter int CLK_SPACING = 1250,
    parameter int DATA_OFFSET = 625
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic        mode_i,
    input  logic [15:0] code_i,
    output logic        pulse_o,
    output logic        done_o
);
    localparam int RW = lpg_cw(PULSE_W + 2);

    lpg_mode_e mode_in;
    logic      start;
    logic      start_norm;
    logic      start_neg;
    lpg_hit_t  hit;
    logic      trig;

    assign mode_in    = lpg_mode_e'(mode_i);
    assign start_norm = start && (mode_in == LPG_NORMAL);
    assign start_neg  = start && (mode_in == LPG_NEGOT);
    assign trig       = start_norm || hit.clk_hit || hit.data_hit;

    lpg_period_timer #(
        .NLP_PERIOD (NLP_PERIOD),
        .FLP_PERIOD (FLP_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .mode_i  (mode_in),
        .start_o (start)
    );

    lpg_burst_seq #(
        .CLK_SPACING (CLK_SPACING),
        .DATA_OFFSET (DATA_OFFSET),
        .PULSE_W     (PULSE_W)
    ) u_burst (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .start_i (start_neg),
        .code_i  (code_i),
        .hit_o   (hit),
        .done_o  (done_o)
    );

    lpg_pulse_stretch #(
        .PULSE_W (PULSE_W)
    ) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .trig_i  (trig),
        .pulse_o (pulse_o)
    );

    // run length of the line, used by the width checks
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)               run_q <= '0;
        else if (!pulse_o)     run_q <= '0;
        else if (run_q != RW'(PULSE_W + 1)) run_q <= run_q + 1'b1;
    end

    // R1: a pulse never exceeds its width
    p_run_cap_r1: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(PULSE_W));

    // R1: a pulse that ends with enable held is exactly PULSE_W long
    p_width_exact_r1: assert property (@(posedge clk) disable iff (rst)
        ($fell(pulse_o) && en_i && $past(en_i)) |-> run_q == RW'(PULSE_W));

    // R8: the end strobe falls on a low cycle of the line
    p_done_low_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !pulse_o);

    // R9: disabled block stays quiet
    p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!pulse_o && !done_o) || en_i);

endmodule

// File: tb/link_pulse_gen_bench.sv
module link_pulse_gen_bench;

    localparam int W    = 2;
    localparam int S    = 20;
    localparam int DOFF = 10;
    localparam int NP   = 100;
    localparam int FP   = 400;
    localparam int MAXN = 1000;
    localparam int BLEN = 16 * S + W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] code = 16'h0;
    logic        pulse_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic cap_p [MAXN];
    logic cap_d [MAXN];
    logic exp_p [MAXN];
    logic exp_d [MAXN];

    always #2 clk = ~clk;

    link_pulse_gen #(
        .PULSE_W     (W),
        .NLP_PERIOD  (NP),
        .FLP_PERIOD  (FP),
        .CLK_SPACING (S),
        .DATA_OFFSET (DOFF)
    ) u_link_pulse_gen (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .mode_i  (mode),
        .code_i  (code),
        .pulse_o (pulse_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_exp();
        for (int i = 0; i < MAXN; i++) begin
            exp_p[i] = 1'b0;
            exp_d[i] = 1'b0;
        end
    endtask

    task automatic add_pulse(input int t);
        for (int j = 0; j < W; j++)
            if (t + j < MAXN) exp_p[t + j] = 1'b1;
    endtask

    task automatic add_burst(input int base, input logic [15:0] w);
        for (int k = 0; k <= 16; k++) add_pulse(base + k * S);
        for (int k = 0; k < 16; k++)
            if (w[k]) add_pulse(base + k * S + DOFF);
        if (base + BLEN < MAXN) exp_d[base + BLEN] = 1'b1;
    endtask

    task automatic mask_from(input int t);
        for (int i = t; i < MAXN; i++) begin
            exp_p[i] = 1'b0;
            exp_d[i] = 1'b0;
        end
    endtask

    task automatic start_run(input logic m, input logic [15:0] w);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        rst  = 1'b0;
        mode = m;
        code = w;
        en   = 1'b1;
    endtask

    // kind: 0 none, 1 code, 2 mode, 3 enable
    task automatic capture(input int n, input int chg_at, input int kind,
                           input logic [15:0] val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_p[i] = pulse_o;
            cap_d[i] = done_o;
            if (i == chg_at) begin
                case (kind)
                    1: code = val;
                    2: mode = val[0];
                    3: en   = val[0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare(input int n, input string req);
        int pm, dm, fp, fd, ra, re;
        pm = 0; dm = 0; fp = -1; fd = -1; ra = 0; re = 0;
        for (int i = 0; i < n; i++) begin
            if (cap_p[i] !== exp_p[i]) begin pm++; if (fp < 0) fp = i; end
            if (cap_d[i] !== exp_d[i]) begin dm++; if (fd < 0) fd = i; end
            if (cap_p[i] === 1'b1 && (i == 0 || cap_p[i-1] !== 1'b1)) ra++;
            if (exp_p[i] && (i == 0 || !exp_p[i-1])) re++;
        end
        check(pm == 0, req, $sformatf("pulse line mismatches (first at %0d)", fp), pm, 0);
        check(dm == 0, req, $sformatf("done strobe mismatches (first at %0d)", fd), dm, 0);
        check(ra == re, req, "pulse count", ra, re);
    endtask

    function automatic int rises(input int lo, input int hi);
        int c = 0;
        for (int i = lo; i <= hi; i++)
            if (cap_p[i] === 1'b1 && (i == 0 || cap_p[i-1] !== 1'b1)) c++;
        return c;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        check(pulse_o === 1'b0, "R9", "pulse after reset", int'(pulse_o), 0);
        check(done_o === 1'b0, "R9", "done after reset", int'(done_o), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(pulse_o === 1'b0 && done_o === 1'b0, "R9", "quiet while disabled",
              int'(pulse_o) + int'(done_o), 0);
    endtask

    task automatic t_normal();
        start_run(1'b0, 16'hFFFF);
        capture(350, -1, 0, 16'h0);
        clear_exp();
        for (int t = 0; t < 350; t += NP) add_pulse(t);
        compare(350, "R1 R2 R8");
    endtask

    task automatic t_burst(input logic [15:0] w);
        int n;
        start_run(1'b1, w);
        capture(900, -1, 0, 16'h0);
        clear_exp();
        add_burst(0, w);
        add_burst(FP, w);
        add_burst(2 * FP, w);
        compare(900, "R3 R4 R6 R8");
        n = rises(0, BLEN);
        check(n == 17 + $countones(w), "R5", $sformatf("burst pulses for %h", w),
              n, 17 + $countones(w));
    endtask

    task automatic t_code_change();
        start_run(1'b1, 16'h00F1);
        capture(800, 50, 1, 16'h8C02);
        clear_exp();
        add_burst(0, 16'h00F1);
        add_burst(FP, 16'h8C02);
        compare(800, "R7");
    endtask

    task automatic t_enable_drop();
        start_run(1'b1, 16'hFFFF);
        capture(500, 150, 3, 16'h0);
        clear_exp();
        add_burst(0, 16'hFFFF);
        mask_from(151);
        compare(500, "R9");
        en = 1'b1;
        capture(400, -1, 0, 16'h0);
        clear_exp();
        add_burst(0, 16'hFFFF);
        compare(400, "R9 restart");
    endtask

    task automatic t_mode_change();
        start_run(1'b0, 16'h1234);
        capture(560, 30, 2, 16'h0001);
        clear_exp();
        add_pulse(0);
        add_burst(NP, 16'h1234);
        add_burst(NP + FP, 16'h1234);
        compare(560, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal();
        t_burst(16'hA5C3);
        t_burst(16'h0000);
        t_burst(16'hFFFF);
        t_code_change();
        t_enable_drop();
        t_mode_change();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule